// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block turns a functional clock into the timing strobes a UART needs. A single 32-bit configuration word, written through a simple write port, sets three things. The first is a modulo divisor that paces a sample tick. The second is an oversampling code that sets how many sample ticks make up one bit period. The last is a group of frame settings: the stop-bit count, whether parity is on, which parity sense is used, and whether both clock edges are used for sampling. The serializer and deserializer sit outside this block. They consume the sample tick, the bit tick and the decoded frame settings.

The bit period in functional-clock cycles is the divisor times the samples per bit. A divisor of zero stops both ticks. Oversampling codes 1 and 2 are reserved. A write that carries one of them keeps the previous code and still applies every other field. Codes 3 to 6 are accepted, but unless dual-edge sampling is selected they raise a misconfiguration flag. Every write restarts both counters, so the new rate is in force from the cycle after the write.

Top module: `baud_tick_gen`

## Requirements
- R1: The divisor D sits in write bits 12:0. When D is not zero, `sample_tick` is high for one cycle in every D. Counting the first cycle after the write edge as cycle 0, the first pulse after a write falls in cycle D-1.
- R2: When the stored divisor is zero, `sample_tick` and `bit_tick` both stay low.
- R3: The oversampling code C sits in write bits 28:24. The samples per bit S are 16 when C is 0 and C+1 otherwise. `bit_tick` is high together with every S-th sample tick. After a write, bit ticks fall in cycles S*D-1, 2*S*D-1, and so on.
- R4: A write whose code is 1 or 2 leaves the stored code unchanged. The divisor and frame fields of that same write are still applied.
- R5: `two_stop` reflects write bit 13: 1 selects two stop bits and 0 selects one.
- R6: `parity_on` reflects write bit 15. `parity_odd` is 1 only when write bits 15 and 16 are both 1, meaning odd parity. Otherwise it is 0, meaning even parity or no parity.
- R7: `dual_edge` reflects write bit 17. `osr_misconfig` is 1 exactly when the stored code lies between 3 and 6 inclusive and dual-edge sampling is off.
- R8: Every write restarts the sample counter and the bit counter, including a write of an unchanged word.
- R9: After reset the stored configuration is all zero. Both ticks stay low and every frame output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe, one cycle |
| cfg_wdata | input | 32 | Configuration word |
| sample_tick | output | 1 | Oversampling strobe, one cycle wide |
| bit_tick | output | 1 | Bit-period strobe, coincides with a sample tick |
| two_stop | output | 1 | Two stop bits selected |
| parity_on | output | 1 | Parity generation and checking enabled |
| parity_odd | output | 1 | Odd parity in force |
| dual_edge | output | 1 | Dual-edge sampling selected |
| osr_misconfig | output | 1 | Code 3..6 chosen without dual-edge sampling |

## Verification
The assertions assume `cfg_we` and `cfg_wdata` are driven to known values on every clock edge once reset has been released. They also assume that a write lasts exactly one cycle per intended update, because a held strobe would keep restarting both counters. The stimulus drives these inputs only between clock edges. It keeps the strobe high for a single cycle and waits for the internal reset release before the first write. It covers divisors from 0 to 5 and codes 0, 1, 2, 3, 4, 7 and 31, so the inputs stay within the ranges the properties describe.

// File: rtl/baud_pkg.sv
package baud_pkg;

  parameter int unsigned CFG_W         = 32;
  parameter int unsigned DIV_W         = 13;
  parameter int unsigned OSR_W         = 5;
  parameter int unsigned SPB_W         = OSR_W + 1;

  // field placement inside the configuration word
  parameter int unsigned DIV_LSB       = 0;
  parameter int unsigned TWO_STOP_POS  = 13;
  parameter int unsigned PAR_EN_POS    = 15;
  parameter int unsigned PAR_ODD_POS   = 16;
  parameter int unsigned DUAL_EDGE_POS = 17;
  parameter int unsigned OSR_LSB       = 24;

  // samples per bit when the ratio code is zero
  parameter int unsigned ZERO_CODE_SPB = 16;

  function automatic logic [SPB_W-1:0] spb_of(input logic [OSR_W-1:0] code);
    if (code == '0) return SPB_W'(ZERO_CODE_SPB);
    return SPB_W'(code) + SPB_W'(1);
  endfunction

  function automatic logic code_reserved(input logic [OSR_W-1:0] code);
    return (code == OSR_W'(1)) || (code == OSR_W'(2));
  endfunction

  function automatic logic code_needs_dual(input logic [OSR_W-1:0] code);
    return (code >= OSR_W'(3)) && (code <= OSR_W'(6));
  endfunction

endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [DIV_W-1:0] div_q,
  output logic [OSR_W-1:0] osr_q,
  output logic             two_stop_q,
  output logic             par_en_q,
  output logic             par_odd_q,
  output logic             dual_edge_q
);

  logic [DIV_W-1:0] div_n;
  logic [OSR_W-1:0] osr_n, osr_w;
  logic             two_stop_n, par_en_n, par_odd_n, dual_edge_n;

  assign osr_w = wdata[OSR_LSB +: OSR_W];

  always_comb begin
    div_n       = div_q;
    osr_n       = osr_q;
    two_stop_n  = two_stop_q;
    par_en_n    = par_en_q;
    par_odd_n   = par_odd_q;
    dual_edge_n = dual_edge_q;
    if (we) begin
      div_n       = wdata[DIV_LSB +: DIV_W];
      two_stop_n  = wdata[TWO_STOP_POS];
      par_en_n    = wdata[PAR_EN_POS];
      par_odd_n   = wdata[PAR_ODD_POS];
      dual_edge_n = wdata[DUAL_EDGE_POS];
      if (!code_reserved(osr_w)) osr_n = osr_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      osr_q       <= '0;
      two_stop_q  <= 1'b0;
      par_en_q    <= 1'b0;
      par_odd_q   <= 1'b0;
      dual_edge_q <= 1'b0;
    end else begin
      div_q       <= div_n;
      osr_q       <= osr_n;
      two_stop_q  <= two_stop_n;
      par_en_q    <= par_en_n;
      par_odd_q   <= par_odd_n;
      dual_edge_q <= dual_edge_n;
    end
  end

  a_r4_reserved_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (we && code_reserved(osr_w)) |=> $stable(osr_q));

  a_r4_code_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !code_reserved(osr_q));

endmodule

// File: rtl/baud_sample_div.sv
module baud_sample_div #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             run;

  assign run  = (div != '0);
  assign tick = run && (cnt_q == DIV_W'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (restart)                   cnt_n = load_val;
    else if (!run)                 cnt_n = '0;
    else if (cnt_q <= DIV_W'(1))   cnt_n = div;
    else                           cnt_n = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  a_r1_count_within_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);

  a_r8_sample_restart_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned SPB_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             samp_tick,
  input  logic [SPB_W-1:0] spb,
  output logic             bit_tick
);

  logic [SPB_W-1:0] cnt_q, cnt_n;
  logic             last;

  assign last     = (cnt_q == spb - SPB_W'(1));
  assign bit_tick = samp_tick && last;

  always_comb begin
    cnt_n = cnt_q;
    if (restart)        cnt_n = '0;
    else if (samp_tick) cnt_n = last ? '0 : cnt_q + SPB_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  a_r3_count_below_spb: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < spb);

  a_r8_bit_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic        sample_tick,
  output logic        bit_tick,
  output logic        two_stop,
  output logic        parity_on,
  output logic        parity_odd,
  output logic        dual_edge,
  output logic        osr_misconfig
);

  logic             rst_s_n;
  logic [DIV_W-1:0] div_q;
  logic [OSR_W-1:0] osr_q;
  logic             two_stop_q, par_en_q, par_odd_q, dual_edge_q;
  logic [SPB_W-1:0] spb;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_s_n)
  );

  baud_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .we          (cfg_we),
    .wdata       (cfg_wdata),
    .div_q       (div_q),
    .osr_q       (osr_q),
    .two_stop_q  (two_stop_q),
    .par_en_q    (par_en_q),
    .par_odd_q   (par_odd_q),
    .dual_edge_q (dual_edge_q)
  );

  assign spb = spb_of(osr_q);

  baud_sample_div #(.DIV_W(DIV_W)) u_samp (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .restart  (cfg_we),
    .load_val (cfg_wdata[DIV_LSB +: DIV_W]),
    .div      (div_q),
    .tick     (sample_tick)
  );

  baud_bit_div #(.SPB_W(SPB_W)) u_bit (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .restart   (cfg_we),
    .samp_tick (sample_tick),
    .spb       (spb),
    .bit_tick  (bit_tick)
  );

  assign two_stop      = two_stop_q;
  assign parity_on     = par_en_q;
  assign parity_odd    = par_en_q & par_odd_q;
  assign dual_edge     = dual_edge_q;
  assign osr_misconfig = code_needs_dual(osr_q) && !dual_edge_q;

  a_r2_off_means_silent: assert property (@(posedge clk) disable iff (!rst_s_n)
    (div_q == '0) |-> (!sample_tick && !bit_tick));

  a_r3_bit_on_sample: assert property (@(posedge clk) disable iff (!rst_s_n)
    bit_tick |-> sample_tick);

  a_r6_odd_needs_enable: assert property (@(posedge clk) disable iff (!rst_s_n)
    parity_odd |-> parity_on);

endmodule

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        sample_tick, bit_tick, two_stop, parity_on, parity_odd, dual_edge, osr_misconfig;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  baud_tick_gen dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .sample_tick   (sample_tick),
    .bit_tick      (bit_tick),
    .two_stop      (two_stop),
    .parity_on     (parity_on),
    .parity_odd    (parity_odd),
    .dual_edge     (dual_edge),
    .osr_misconfig (osr_misconfig)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [12:0] div;
    logic [4:0]  code;
    logic        stop;
    logic        pe;
    logic        po;
    logic        de;
    logic        misc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{div:13'd3, code:5'd0,  stop:1'b0, pe:1'b0, po:1'b0, de:1'b0, misc:1'b0},
    '{div:13'd1, code:5'd4,  stop:1'b0, pe:1'b0, po:1'b1, de:1'b0, misc:1'b1},
    '{div:13'd2, code:5'd4,  stop:1'b1, pe:1'b1, po:1'b0, de:1'b1, misc:1'b0},
    '{div:13'd5, code:5'd7,  stop:1'b1, pe:1'b1, po:1'b1, de:1'b0, misc:1'b0},
    '{div:13'd4, code:5'd31, stop:1'b0, pe:1'b0, po:1'b0, de:1'b1, misc:1'b0},
    '{div:13'd1, code:5'd3,  stop:1'b0, pe:1'b1, po:1'b0, de:1'b0, misc:1'b1}
  };

  function automatic logic [31:0] mk(input logic [12:0] d, input logic [4:0] c,
                                     input logic s, input logic pe, input logic po, input logic de);
    logic [31:0] w;
    w        = '0;
    w[12:0]  = d;
    w[13]    = s;
    w[15]    = pe;
    w[16]    = po;
    w[17]    = de;
    w[28:24] = c;
    return w;
  endfunction

  function automatic int spb(input logic [4:0] c);
    return (c == 0) ? 16 : int'(c) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = '0;
  endtask

  // called on the negedge right after the write edge (cycle 0)
  task automatic measure(input int lim, output int fs, output int fb, output int sb, output int ns);
    fs = -1; fb = -1; sb = -1; ns = 0;
    for (int k = 0; k < lim; k++) begin
      if (sample_tick) begin
        ns++;
        if (fs < 0) fs = k;
      end
      if (bit_tick) begin
        if (fb < 0) fb = k;
        else if (sb < 0) sb = k;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int fs, fb, sb, ns, s, d;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk({two_stop, parity_on, parity_odd, dual_edge, osr_misconfig} == 5'b0, "R9 frame outputs",
        int'({two_stop, parity_on, parity_odd, dual_edge, osr_misconfig}), 0);
    measure(50, fs, fb, sb, ns);
    chk(ns == 0 && fb < 0, "R9 no ticks after reset", ns, 0);

    // table walk: R1 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      d = int'(VECS[i].div);
      s = spb(VECS[i].code);
      wr(mk(VECS[i].div, VECS[i].code, VECS[i].stop, VECS[i].pe, VECS[i].po, VECS[i].de));
      chk(two_stop == VECS[i].stop, "R5 two_stop", two_stop, VECS[i].stop);
      chk(parity_on == VECS[i].pe, "R6 parity_on", parity_on, VECS[i].pe);
      chk(parity_odd == (VECS[i].pe & VECS[i].po), "R6 parity_odd", parity_odd, VECS[i].pe & VECS[i].po);
      chk(dual_edge == VECS[i].de, "R7 dual_edge", dual_edge, VECS[i].de);
      chk(osr_misconfig == VECS[i].misc, "R7 osr_misconfig", osr_misconfig, VECS[i].misc);
      measure(2 * s * d + 4, fs, fb, sb, ns);
      chk(fs == d - 1, "R1 first sample tick", fs, d - 1);
      chk(fb == s * d - 1, "R3 first bit tick", fb, s * d - 1);
      chk(sb == 2 * s * d - 1, "R3 second bit tick", sb, 2 * s * d - 1);
    end

    // R4: reserved code 1 keeps code 7, divisor still updated to 3
    wr(mk(13'd2, 5'd7, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(mk(13'd3, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0));
    chk(two_stop == 1'b1, "R4 other fields applied", two_stop, 1);
    measure(60, fs, fb, sb, ns);
    chk(fs == 2, "R4 divisor applied", fs, 2);
    chk(fb == 23, "R4 code 1 rejected", fb, 23);
    // R4: reserved code 2 also refused; misconfig stays clear
    wr(mk(13'd1, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0));
    chk(osr_misconfig == 1'b0, "R4 code 2 misconfig", osr_misconfig, 0);
    measure(20, fs, fb, sb, ns);
    chk(fb == 7, "R4 code 2 rejected", fb, 7);

    // R2: divisor zero silences both ticks
    wr(mk(13'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    measure(100, fs, fb, sb, ns);
    chk(ns == 0, "R2 no sample ticks", ns, 0);
    chk(fb < 0, "R2 no bit ticks", fb, -1);

    // R8: rewriting the same word mid-period restarts counting
    wr(mk(13'd4, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1));
    repeat (6) @(negedge clk);
    wr(mk(13'd4, 5'd3, 1'b0, 1'b0, 1'b0, 1'b1));
    measure(40, fs, fb, sb, ns);
    chk(fs == 3, "R8 sample restart", fs, 3);
    chk(fb == 15, "R8 bit restart", fb, 15);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule